// File: doc/BRIEF.md
# Bridge Interrupt Status and IRQ Router

This block collects interrupt activity for a bus bridge that can act as host or target. Seven internal event sources each set a sticky status flag; software reads the flags in one 32-bit status word and clears them by writing ones. One of the seven events comes from a built-in watchdog. That watchdog fires when a target access stays pending without a retry for 2^TMO_BITS clock cycles. Four active-low legacy interrupt lines from the bus are synchronised. Their live levels are shown in the same word.

A 2-bit routing mode, `irq_mode_i`, places the legacy interrupts, a combined error interrupt and the DMA interrupt onto a group of five IRQ outputs (base line 0 through base+4). The mode selects whether they share the base line or are spread across the group. The rest of the word reports fixed build options and live configuration-access flags. Those fields are read-only.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, status bits 18:12 read 0, bits 11:8 read 4'hF and all IRQ outputs are low.
- R2: A high pulse on `evt_i[k]` (k=0 parity error, 1 target abort, 2 master abort, 3 DMA error, 4 DMA done, 5 system error) sets word bit 12+k at that clock edge. The bit then holds until it is cleared.
- R3: A write (`reg_wr_i`=1) clears each status bit 18:12 whose write-data bit is 1. Bits written with 0 and all other fields are unchanged.
- R4: When a status bit is set by an event and cleared by a write in the same cycle, it stays set.
- R5: Bits 11:8 show `intx_n_i[3:0]` (bit 8 = line A) two clock edges after the input changes. A bit reads 0 while its line is asserted (low).
- R6: Word bit 18 is set when `tgt_pend_i` is high and `tgt_retry_i` is low for 2^TMO_BITS consecutive edges. A low pend or a high retry restarts the count. The event fires once per pending episode.
- R7: Mode 00: irq_o[0] = any legacy | err | dma; irq_o[4:1] = 0.
- R8: Mode 01: irq_o[0] = any legacy | err; irq_o[1] = dma; irq_o[4:2] = 0.
- R9: Mode 10: irq_o[k] = legacy line k for k=0..3; err and dma are also ORed onto irq_o[0]; irq_o[4] = 0.
- R10: Mode 11: irq_o[k] = legacy line k for k=0..3; err is also ORed onto irq_o[0]; irq_o[4] = dma.
- R11: err is the OR of status bits 12,13,14,15,17,18 (those enabled by ERR_MASK, all by default). dma is status bit 16.
- R12: The fixed fields are as follows. Bit 31 = `slot_n_i`. Bits 30:26 = CAP_BITS. Bits 25:24 = `irq_mode_i`. Bit 23 = TRACE_EN. Bits 22:21 = 0. Bit 20 = `cfg_done_i`. Bit 19 = `cfg_err_i`. Bits 7:5 = 0. Bits 4:2 = FIFO_DEPTH_LOG. Bits 1:0 = FIFO_NUM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses for status bits 12..17 |
| tgt_pend_i | input | 1 | Target access waiting for a retry |
| tgt_retry_i | input | 1 | Pending access was retried |
| intx_n_i | input | 4 | Legacy interrupt lines, active low, bit 0 = A |
| slot_n_i | input | 1 | System-slot strap, 0 = may act as host |
| cfg_done_i | input | 1 | Configuration access finished |
| cfg_err_i | input | 1 | Configuration access error |
| irq_mode_i | input | 2 | Routing mode |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data (ones clear status bits) |
| reg_rdata_o | output | 32 | Status and capability word |
| irq_o | output | 5 | Routed IRQ lines, base at bit 0 |

## Verification
A wrong sticky flag appears in bits 18:12 of the read word one edge after the event or write that caused it. In the same cycle it appears on the IRQ line chosen by the mode. A synchroniser fault moves the change in bits 11:8 away from the second edge. A watchdog counting error sets bit 18 one edge early or late, or sets it twice for a single episode. The bench compares the whole word and the IRQ vector with a behavioural model after every edge, so any of these faults is reported in the cycle it first appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LEG_N   = 4;
  localparam int IRQ_N   = LEG_N + 1;
  localparam int STS_N   = 7;
  localparam int BIT_DMA = 4;
  localparam int BIT_TMO = 6;

  typedef enum logic [1:0] {
    RT_SHARED      = 2'b00,
    RT_DMA_SPLIT   = 2'b01,
    RT_LEG_SPREAD  = 2'b10,
    RT_FULL_SPREAD = 2'b11
  } route_mode_e;

  function automatic logic err_any(input logic [STS_N-1:0] sts, input logic [STS_N-1:0] mask);
    return |(sts & mask);
  endfunction

  function automatic logic [IRQ_N-1:0] route_irqs(input route_mode_e mode,
                                                   input logic [LEG_N-1:0] leg,
                                                   input logic err, input logic dma);
    logic [IRQ_N-1:0] o;
    o = '0;
    case (mode)
      RT_SHARED:     o[0] = (|leg) | err | dma;
      RT_DMA_SPLIT:  begin o[0] = (|leg) | err; o[1] = dma; end
      RT_LEG_SPREAD: begin o[LEG_N-1:0] = leg; o[0] = leg[0] | err | dma; end
      default:       begin o[LEG_N-1:0] = leg; o[0] = leg[0] | err; o[LEG_N] = dma; end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg_q[s] <= RST_VAL;
        else if (s == 0) stg_q[s] <= d_i;
        else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_tmo_cnt.sv
module irq_tmo_cnt #(
  parameter int TMO_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic retry_i,
  output logic tmo_o
);
  localparam int CW = TMO_BITS + 1;
  localparam logic [CW-1:0] LIMIT = CW'(1) << TMO_BITS;

  logic [CW-1:0] cnt_q;
  logic          run;

  assign run   = pend_i && !retry_i;
  assign tmo_o = run && (cnt_q == LIMIT - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !tmo_o); // R6
  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tmo_o); // R6
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i))); // R4
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((sts_q & $past(clr_i) & ~$past(set_i)) == '0)); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(sts_q)); // R2
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_pkg::*;
#(
  parameter int              TMO_BITS       = 15,
  parameter logic [4:0]      CAP_BITS       = 5'b11111,
  parameter logic            TRACE_EN       = 1'b0,
  parameter logic [2:0]      FIFO_DEPTH_LOG = 3'd3,
  parameter logic [1:0]      FIFO_NUM       = 2'd2,
  parameter logic [STS_N-1:0] ERR_MASK      = 7'b110_1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       evt_i,
  input  logic             tgt_pend_i,
  input  logic             tgt_retry_i,
  input  logic [3:0]       intx_n_i,
  input  logic             slot_n_i,
  input  logic             cfg_done_i,
  input  logic             cfg_err_i,
  input  logic [1:0]       irq_mode_i,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic [4:0]       irq_o
);
  localparam int STS_LSB = 12;

  logic [LEG_N-1:0] intx_sync_n;
  logic             tmo_evt;
  logic [STS_N-1:0] sts_set, sts_clr, sts;
  logic             err_irq, dma_irq;
  route_mode_e      mode;

  irq_sync #(.W(LEG_N), .STAGES(2), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(intx_n_i), .q_o(intx_sync_n));

  irq_tmo_cnt #(.TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .pend_i(tgt_pend_i), .retry_i(tgt_retry_i), .tmo_o(tmo_evt));

  assign sts_set = {tmo_evt, evt_i};
  assign sts_clr = reg_wr_i ? reg_wdata_i[STS_LSB +: STS_N] : '0;

  irq_sticky #(.W(STS_N)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_i(sts_clr), .sts_o(sts));

  assign mode    = route_mode_e'(irq_mode_i);
  assign err_irq = err_any(sts, ERR_MASK);
  assign dma_irq = sts[BIT_DMA];
  assign irq_o   = route_irqs(mode, ~intx_sync_n, err_irq, dma_irq);

  assign reg_rdata_o = {slot_n_i, CAP_BITS, irq_mode_i, TRACE_EN, 2'b00,
                        cfg_done_i, cfg_err_i, sts, intx_sync_n,
                        3'b000, FIFO_DEPTH_LOG, FIFO_NUM};

  AST_SHARED_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RT_SHARED) |-> (irq_o[4:1] == '0)); // R7
  AST_SPLIT_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RT_DMA_SPLIT) |-> (irq_o[4:2] == '0)); // R8
  AST_LEG_SPREAD_TOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RT_LEG_SPREAD) |-> !irq_o[4]); // R9
  AST_TMO_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> reg_rdata_o[STS_LSB + BIT_TMO]); // R6
endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
  localparam int TMO_BITS = 15;
  localparam int LIMIT    = 1 << TMO_BITS;
  localparam logic [4:0] CAP = 5'b11111;
  localparam logic [6:0] EMASK = 7'b110_1111;

  logic clk = 0, rst_n = 0;
  logic [5:0] evt = 0;
  logic pend = 0, retry = 0, slot_n = 1, cdone = 0, cerr = 0, wr = 0;
  logic [3:0] intx_n = 4'hF;
  logic [1:0] mode = 0;
  logic [31:0] wdata = 0, rdata;
  logic [4:0] irq;

  int tests = 0, fails = 0, cycles = 0;

  pci_irq_router #(.TMO_BITS(TMO_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tgt_pend_i(pend), .tgt_retry_i(retry),
    .intx_n_i(intx_n), .slot_n_i(slot_n), .cfg_done_i(cdone), .cfg_err_i(cerr),
    .irq_mode_i(mode), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  always #5 clk = ~clk;

  // behavioural reference model
  bit [6:0] m_sts;
  bit [3:0] m_s1, m_s2;
  int m_cnt, m_tmo_hits;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_s1 = 4'hF; m_s2 = 4'hF; m_cnt = 0; m_tmo_hits = 0;
    end else begin
      bit fire;
      fire = 0;
      if (!pend || retry) m_cnt = 0;
      else begin
        m_cnt++;
        if (m_cnt == LIMIT) begin fire = 1; m_tmo_hits++; end
      end
      if (wr) m_sts = m_sts & ~wdata[18:12];
      m_sts = m_sts | {fire, evt};
      m_s2 = m_s1; m_s1 = intx_n;
    end
  end

  function automatic bit [4:0] model_irq(bit [1:0] md, bit [6:0] st, bit [3:0] lines_n);
    bit [4:0] r;
    bit err, dma;
    int dline;
    r = 0;
    err = 0;
    for (int k = 0; k < 7; k++) if (EMASK[k] && st[k]) err = 1;
    dma = st[4];
    for (int k = 0; k < 4; k++) if (!lines_n[k]) r[md[1] ? k : 0] = 1;
    if (err) r[0] = 1;
    dline = (md == 2'b01) ? 1 : (md == 2'b11) ? 4 : 0;
    if (dma) r[dline] = 1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit [31:0] ew;
    bit [4:0] ei;
    string rq;
    cycles++;
    ew = {slot_n, CAP, mode, 1'b0, 2'b00, cdone, cerr, m_sts, m_s2, 3'b000, 3'd3, 2'd2};
    ei = model_irq(mode, m_sts, m_s2);
    check(rdata[18:12] == ew[18:12], "R2 status", rdata, ew);
    check(rdata[11:8] == ew[11:8], "R5 host lines", rdata, ew);
    check({rdata[31:19], rdata[7:0]} == {ew[31:19], ew[7:0]}, "R12 fixed fields", rdata, ew);
    case (mode)
      2'b00: rq = "R7 route"; 2'b01: rq = "R8 route";
      2'b10: rq = "R9 route"; default: rq = "R10 route";
    endcase
    check(irq == ei, rq, irq, ei);
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_evt(bit [5:0] v);
    evt = v; tick(); evt = 0;
  endtask

  task automatic wr1c(bit [6:0] v);
    wr = 1; wdata = 32'hFFF8_0FFF & 32'h0000_0000 | ({25'd0, v} << 12); tick(); wr = 0; wdata = 0;
  endtask

  initial begin
    tick(3);
    check(rdata[18:12] == 0 && rdata[11:8] == 4'hF && irq == 0, "R1 reset", rdata, 32'h0000_0F00);
    rst_n = 1;
    tick(2);
    // R2: each event sets its own bit
    for (int k = 0; k < 6; k++) begin
      pulse_evt(6'b1 << k);
      #1 check(rdata[12+k] == 1'b1, "R2 set bit", rdata[18:12], 7'b1 << k);
      tick();
    end
    // R3: clear a subset, others unchanged
    wr1c(7'b000_0101);
    #1 check(rdata[18:12] == 7'b011_1010, "R3 w1c", rdata[18:12], 7'b011_1010);
    wr1c(7'b000_0000);
    #1 check(rdata[18:12] == 7'b011_1010, "R3 zero write", rdata[18:12], 7'b011_1010);
    // R4: set wins over clear
    evt = 6'b00_1000; wr = 1; wdata = 32'h0000_8000; tick(); evt = 0; wr = 0; wdata = 0;
    #1 check(rdata[15] == 1'b1, "R4 set beats clear", rdata[18:12], 7'b011_1010);
    wr1c(7'h7F);
    #1 check(rdata[18:12] == 0 && irq == 0, "R3 clear all", rdata[18:12], 0);
    // R11: DMA bit alone, mode 01 puts it on line 1 only
    mode = 2'b01;
    pulse_evt(6'b01_0000);
    #1 check(irq == 5'b00010, "R11 dma to line1", irq, 5'b00010);
    wr1c(7'h10);
    pulse_evt(6'b10_0000);
    #1 check(irq == 5'b00001, "R11 syserr is error", irq, 5'b00001);
    wr1c(7'h7F);
    // R5 and routing with legacy lines in all modes
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      intx_n = 4'b0101;
      tick();
      #1 check(rdata[11:8] == 4'hF, "R5 one edge not yet", rdata[11:8], 4'hF);
      tick();
      #1 check(rdata[11:8] == 4'b0101, "R5 two edges", rdata[11:8], 4'b0101);
      pulse_evt(6'b01_0001);
      tick(2);
      wr1c(7'h7F);
      intx_n = 4'hF;
      tick(3);
    end
    cdone = 1; cerr = 1; slot_n = 0; tick(2); cdone = 0; tick(); cerr = 0; slot_n = 1;
    // R6: one short of the limit -> no event
    mode = 2'b11;
    pend = 1; tick(LIMIT - 1); pend = 0; tick();
    #1 check(rdata[18] == 1'b0, "R6 below limit", rdata[18:12], 0);
    // retry restarts the count
    pend = 1; tick(LIMIT - 10); retry = 1; tick(); retry = 0; tick(LIMIT - 20);
    #1 check(rdata[18] == 1'b0, "R6 retry restarts", rdata[18:12], 0);
    tick(30);
    #1 check(rdata[18] == 1'b1, "R6 timeout set", rdata[18:12], 7'h40);
    wr1c(7'h40);
    tick(100);
    #1 check(rdata[18] == 1'b0, "R6 fires once", rdata[18:12], 0);
    pend = 0; tick(3);
    check(m_tmo_hits == 1, "R6 hit count", m_tmo_hits, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule